// File: doc/BRIEF.md
# Keyboard and Mouse Host Interface Controller

This block is the host-facing half of a legacy keyboard and mouse controller. The host sees two byte-wide ports: a data port (the 60h address, selected with `host_port = 0`) and a command/status port (the 64h address, `host_port = 1`). Every host write lands in a single one-byte input buffer and is tagged as a command or as data. A command engine then decodes the byte. It keeps an 8-bit command byte and a one-byte scratch RAM, and it loads responses into a single one-byte output buffer. Reads of the data port return that buffer. Reads of the command/status port return a status byte built from internal flags.

The keyboard and mouse sides are modelled as byte handshakes rather than serial lines. Received bytes arrive on valid/ready inputs and are moved into the output buffer while it is empty and the source is enabled. Each accepted byte can latch its interrupt, and a data-port read clears both interrupts. Host data bytes are sent out on valid/ready transmit ports. An active-low keyboard-inhibit input makes the block consume and discard keyboard bytes, unless the command byte overrides it.

The command engine has these states:
- `ST_IDLE` decodes commands. A data byte moves it to `ST_SEND_KB`.
- Command 60h moves it to `ST_WAIT_CB`, a command in 61h–6Fh to `ST_WAIT_RAM`, and command D4h to `ST_WAIT_AUX`.
- From the three wait states, a data byte returns it to `ST_IDLE` (after a command-byte write or a RAM write), or moves it to `ST_SEND_AUX` (from `ST_WAIT_AUX`).
- A command arriving in any wait state cancels the wait and is decoded as if the engine were in `ST_IDLE`.
- `ST_SEND_KB` and `ST_SEND_AUX` hold their transmit valid until ready, then return to `ST_IDLE`.

Top module: `kbc_host_ctrl`

## Requirements
- R1: A host write accepted at a clock edge sets status bit 1 (input busy) from that edge onward. Status bit 3 becomes 1 for a write to the command port and 0 for a write to the data port. A command byte is processed, and busy is cleared, at the next edge.
- R2: The status byte is: bit 0 = output buffer full; bit 1 = input busy; bit 2 = system flag (command byte bit 2); bit 3 = last write was a command; bit 4 = 1 while `kb_inhibit_n` is low; bit 5 = output byte came from the mouse; bits 7:6 = 0. After reset the status byte is 00h while `kb_inhibit_n` is high.
- R3: A read of the data port returns the output buffer. The same read clears output-full, `irq_kb` and `irq_ms`. Reading the status port has no side effect.
- R4: A data-port write while no command is waiting for data drives `kb_tx_valid` with that byte. Valid and data stay stable, and input busy stays 1, until `kb_tx_ready` is seen.
- R5: After command D4h, the next data byte is sent on `ms_tx_valid`/`ms_tx_data` instead, under the same handshake. The two transmit valids are never high together.
- R6: Command 20h places the command byte in the output buffer. Command 60h followed by a data byte replaces the command byte. The command byte resets to `CB_RESET` (default 03h).
- R7: Commands 21h–2Fh return, and commands 61h–6Fh followed by a data byte write, one shared scratch byte. The scratch byte resets to 00h.
- R8: A7h sets command-byte bit 5 (mouse disabled) and A8h clears it. ADh sets bit 4 (keyboard disabled) and AEh clears it. A disabled source sees its rx ready held low.
- R9: AAh returns `SELF_TEST_PASS` (default 55h). A9h and ABh return `IF_TEST_PASS` (default 00h). Every controller response clears status bit 5.
- R10: A device byte is accepted only while the output buffer is empty, the source is enabled and no controller response loads in that cycle. When both sources offer a byte, the keyboard wins. A full buffer holds its byte until a data-port read.
- R11: An accepted keyboard byte sets `irq_kb` when command-byte bit 0 is 1. An accepted mouse byte sets `irq_ms` when command-byte bit 1 is 1. Each interrupt stays set until a data-port read.
- R12: While `kb_inhibit_n` is low and command-byte bit 3 is 0, keyboard bytes are consumed (ready high) and dropped, with no buffer load and no interrupt. Mouse bytes are unaffected. Setting bit 3 lets keyboard bytes through.
- R13: Unknown command codes change nothing. A command written while a wait state is pending cancels the wait and executes.
- R14: A host write made while input busy is 1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effect on the data port only) |
| host_port | input | 1 | 0 = data port, 1 = command/status port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Output buffer (data port) or status byte (command port) |
| kb_inhibit_n | input | 1 | Active-low keyboard inhibit |
| kb_rx_valid | input | 1 | Keyboard byte offered |
| kb_rx_data | input | 8 | Keyboard byte |
| kb_rx_ready | output | 1 | Keyboard byte taken |
| ms_rx_valid | input | 1 | Mouse byte offered |
| ms_rx_data | input | 8 | Mouse byte |
| ms_rx_ready | output | 1 | Mouse byte taken |
| kb_tx_valid | output | 1 | Byte for the keyboard is valid |
| kb_tx_data | output | 8 | Byte for the keyboard |
| kb_tx_ready | input | 1 | Keyboard side accepts the byte |
| ms_tx_valid | output | 1 | Byte for the mouse is valid |
| ms_tx_data | output | 8 | Byte for the mouse |
| ms_tx_ready | input | 1 | Mouse side accepts the byte |
| irq_kb | output | 1 | Latched keyboard interrupt |
| irq_ms | output | 1 | Latched mouse interrupt |

## Verification
The bench builds the block with its default parameters: command byte resetting to 03h, self-test result 55h and interface-test result 00h. Both interrupt enables are therefore live from reset, so interrupt latching and clearing can be seen without first programming the command byte. The distinct self-test and interface-test values also let a swapped response decode show up. The fixed 03h start makes each set/clear command yield a unique readback through 20h.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] kbc_byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_CB,
        ST_WAIT_RAM,
        ST_WAIT_AUX,
        ST_SEND_KB,
        ST_SEND_AUX
    } kbc_state_e;

    localparam kbc_byte_t OP_RD_CB     = 8'h20;
    localparam kbc_byte_t OP_RD_RAM_LO = 8'h21;
    localparam kbc_byte_t OP_RD_RAM_HI = 8'h2F;
    localparam kbc_byte_t OP_WR_CB     = 8'h60;
    localparam kbc_byte_t OP_WR_RAM_LO = 8'h61;
    localparam kbc_byte_t OP_WR_RAM_HI = 8'h6F;
    localparam kbc_byte_t OP_AUX_OFF   = 8'hA7;
    localparam kbc_byte_t OP_AUX_ON    = 8'hA8;
    localparam kbc_byte_t OP_AUX_TEST  = 8'hA9;
    localparam kbc_byte_t OP_SELF_TEST = 8'hAA;
    localparam kbc_byte_t OP_KB_TEST   = 8'hAB;
    localparam kbc_byte_t OP_KB_OFF    = 8'hAD;
    localparam kbc_byte_t OP_KB_ON     = 8'hAE;
    localparam kbc_byte_t OP_TO_AUX    = 8'hD4;

    // command byte fields
    localparam int CB_KB_IRQ  = 0;
    localparam int CB_AUX_IRQ = 1;
    localparam int CB_SYS     = 2;
    localparam int CB_INH_OVR = 3;
    localparam int CB_KB_DIS  = 4;
    localparam int CB_AUX_DIS = 5;
endpackage

// File: rtl/kbc_in_buf.sv
module kbc_in_buf
    import kbc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      host_wr,
    input  logic      host_port,
    input  kbc_byte_t host_wdata,
    input  logic      consume,
    output logic      ibf,
    output logic      ib_is_cmd,
    output kbc_byte_t ib_data
);
    logic accept;
    assign accept = host_wr && !ibf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ibf       <= 1'b0;
            ib_is_cmd <= 1'b0;
            ib_data   <= '0;
        end else begin
            if (accept) begin
                ibf       <= 1'b1;
                ib_is_cmd <= host_port;
                ib_data   <= host_wdata;
            end else if (consume) begin
                ibf <= 1'b0;
            end
        end
    end

    // a busy buffer keeps its byte: later writes are lost
    assert_busy_drop_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && !consume) |=> (ibf && $stable(ib_data) && $stable(ib_is_cmd)));

    assert_busy_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibf) |-> $past(host_wr));
endmodule

// File: rtl/kbc_cmd_fsm.sv
module kbc_cmd_fsm
    import kbc_pkg::*;
#(
    parameter kbc_byte_t CB_RESET       = 8'h03,
    parameter kbc_byte_t SELF_TEST_PASS = 8'h55,
    parameter kbc_byte_t IF_TEST_PASS   = 8'h00
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ibf,
    input  logic      ib_is_cmd,
    input  kbc_byte_t ib_data,
    input  logic      kb_tx_ready,
    input  logic      ms_tx_ready,
    output logic      consume,
    output logic      kb_tx_valid,
    output logic      ms_tx_valid,
    output kbc_byte_t tx_data,
    output logic      resp_load,
    output kbc_byte_t resp_data,
    output kbc_byte_t cmd_byte
);
    kbc_state_e state, state_n;
    kbc_byte_t  ram_q;

    // decoded view of the buffered command
    kbc_state_e dec_next;
    logic       dec_resp;
    kbc_byte_t  dec_rdata;
    kbc_byte_t  dec_set;
    kbc_byte_t  dec_clr;

    logic take_cmd;
    logic cb_wr;
    logic ram_wr;

    assign tx_data = ib_data;

    always_comb begin
        dec_next  = ST_IDLE;
        dec_resp  = 1'b0;
        dec_rdata = '0;
        dec_set   = '0;
        dec_clr   = '0;
        if (ib_data == OP_RD_CB) begin
            dec_resp  = 1'b1;
            dec_rdata = cmd_byte;
        end else if (ib_data >= OP_RD_RAM_LO && ib_data <= OP_RD_RAM_HI) begin
            dec_resp  = 1'b1;
            dec_rdata = ram_q;
        end else if (ib_data == OP_WR_CB) begin
            dec_next = ST_WAIT_CB;
        end else if (ib_data >= OP_WR_RAM_LO && ib_data <= OP_WR_RAM_HI) begin
            dec_next = ST_WAIT_RAM;
        end else if (ib_data == OP_TO_AUX) begin
            dec_next = ST_WAIT_AUX;
        end else if (ib_data == OP_AUX_OFF) begin
            dec_set[CB_AUX_DIS] = 1'b1;
        end else if (ib_data == OP_AUX_ON) begin
            dec_clr[CB_AUX_DIS] = 1'b1;
        end else if (ib_data == OP_KB_OFF) begin
            dec_set[CB_KB_DIS] = 1'b1;
        end else if (ib_data == OP_KB_ON) begin
            dec_clr[CB_KB_DIS] = 1'b1;
        end else if (ib_data == OP_SELF_TEST) begin
            dec_resp  = 1'b1;
            dec_rdata = SELF_TEST_PASS;
        end else if (ib_data == OP_AUX_TEST || ib_data == OP_KB_TEST) begin
            dec_resp  = 1'b1;
            dec_rdata = IF_TEST_PASS;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state and outputs
    always_comb begin
        state_n     = state;
        consume     = 1'b0;
        take_cmd    = 1'b0;
        resp_load   = 1'b0;
        resp_data   = dec_rdata;
        cb_wr       = 1'b0;
        ram_wr      = 1'b0;
        kb_tx_valid = 1'b0;
        ms_tx_valid = 1'b0;
        unique case (state)
            ST_IDLE, ST_WAIT_CB, ST_WAIT_RAM, ST_WAIT_AUX: begin
                if (ibf) begin
                    if (ib_is_cmd) begin
                        consume   = 1'b1;
                        take_cmd  = 1'b1;
                        resp_load = dec_resp;
                        state_n   = dec_next;
                    end else if (state == ST_WAIT_CB) begin
                        consume = 1'b1;
                        cb_wr   = 1'b1;
                        state_n = ST_IDLE;
                    end else if (state == ST_WAIT_RAM) begin
                        consume = 1'b1;
                        ram_wr  = 1'b1;
                        state_n = ST_IDLE;
                    end else if (state == ST_WAIT_AUX) begin
                        state_n = ST_SEND_AUX;
                    end else begin
                        state_n = ST_SEND_KB;
                    end
                end
            end
            ST_SEND_KB: begin
                kb_tx_valid = 1'b1;
                if (kb_tx_ready) begin
                    consume = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            ST_SEND_AUX: begin
                ms_tx_valid = 1'b1;
                if (ms_tx_ready) begin
                    consume = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_byte <= CB_RESET;
            ram_q    <= '0;
        end else begin
            if (cb_wr)
                cmd_byte <= ib_data;
            else if (take_cmd)
                cmd_byte <= (cmd_byte | dec_set) & ~dec_clr;
            if (ram_wr)
                ram_q <= ib_data;
        end
    end

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_tx_valid && !kb_tx_ready) |=> (kb_tx_valid && $stable(tx_data) && ibf));

    assert_tx_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kb_tx_valid, ms_tx_valid}));

    assert_cb_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_CB && ibf && !ib_is_cmd) |=> (cmd_byte == $past(ib_data)));

    assert_ram_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RAM && ibf && !ib_is_cmd) |=> (ram_q == $past(ib_data)));
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf
    import kbc_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            resp_load,
    input  kbc_byte_t       resp_data,
    input  logic            host_rd_data,
    input  logic [NSRC-1:0] src_valid,
    input  kbc_byte_t       src_data [NSRC],
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_drop,
    input  logic [NSRC-1:0] src_irq_en,
    output logic [NSRC-1:0] src_ready,
    output logic [NSRC-1:0] irq,
    output logic            obf,
    output logic            aux,
    output kbc_byte_t       obuf
);
    logic [NSRC:0]   free;
    logic [NSRC-1:0] take;

    assign free[0] = !obf && !resp_load;

    // lower index has priority over higher index
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign src_ready[i] = src_en[i] && (src_drop[i] || free[i]);
        assign take[i]      = src_valid[i] && src_en[i] && !src_drop[i] && free[i];
        assign free[i+1]    = free[i] && !(src_valid[i] && src_en[i] && !src_drop[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obf  <= 1'b0;
            aux  <= 1'b0;
            obuf <= '0;
            irq  <= '0;
        end else begin
            if (host_rd_data) begin
                obf <= 1'b0;
                irq <= '0;
            end
            if (resp_load) begin
                obf  <= 1'b1;
                aux  <= 1'b0;
                obuf <= resp_data;
            end else begin
                for (int k = 0; k < NSRC; k++) begin
                    if (take[k]) begin
                        obf    <= 1'b1;
                        aux    <= (k != 0);
                        obuf   <= src_data[k];
                        irq[k] <= src_irq_en[k];
                    end
                end
            end
        end
    end

    assert_rd_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_data && !resp_load && take == '0) |=> (!obf && irq == '0));

    assert_hold_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (obf && !host_rd_data && !resp_load) |=> (obf && $stable(obuf)));

    assert_irq_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> $past(src_irq_en[0]));

    assert_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (src_drop[0] && src_valid[0] && !src_valid[1] && !resp_load && !obf) |=> !obf);
endmodule

// File: rtl/kbc_host_ctrl.sv
module kbc_host_ctrl
    import kbc_pkg::*;
#(
    parameter logic [7:0] CB_RESET       = 8'h03,
    parameter logic [7:0] SELF_TEST_PASS = 8'h55,
    parameter logic [7:0] IF_TEST_PASS   = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_port,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       kb_inhibit_n,
    input  logic       kb_rx_valid,
    input  logic [7:0] kb_rx_data,
    output logic       kb_rx_ready,
    input  logic       ms_rx_valid,
    input  logic [7:0] ms_rx_data,
    output logic       ms_rx_ready,
    output logic       kb_tx_valid,
    output logic [7:0] kb_tx_data,
    input  logic       kb_tx_ready,
    output logic       ms_tx_valid,
    output logic [7:0] ms_tx_data,
    input  logic       ms_tx_ready
    ,
    output logic       irq_kb,
    output logic       irq_ms
);
    localparam int NSRC = 2;

    logic      ibf, ib_is_cmd, consume;
    kbc_byte_t ib_data, tx_data, cmd_byte, resp_data, obuf;
    logic      resp_load, obf, aux, kb_blocked;
    logic [NSRC-1:0] src_ready, irq;
    kbc_byte_t src_data [NSRC];
    kbc_byte_t status;

    kbc_in_buf u_in (
        .clk, .rst_n, .host_wr, .host_port, .host_wdata,
        .consume, .ibf, .ib_is_cmd, .ib_data
    );

    kbc_cmd_fsm #(
        .CB_RESET(CB_RESET), .SELF_TEST_PASS(SELF_TEST_PASS), .IF_TEST_PASS(IF_TEST_PASS)
    ) u_fsm (
        .clk, .rst_n, .ibf, .ib_is_cmd, .ib_data, .kb_tx_ready, .ms_tx_ready,
        .consume, .kb_tx_valid, .ms_tx_valid, .tx_data, .resp_load, .resp_data,
        .cmd_byte
    );

    assign kb_blocked  = !kb_inhibit_n && !cmd_byte[CB_INH_OVR];
    assign src_data[0] = kb_rx_data;
    assign src_data[1] = ms_rx_data;

    kbc_out_buf #(.NSRC(NSRC)) u_out (
        .clk, .rst_n, .resp_load, .resp_data,
        .host_rd_data(host_rd && !host_port),
        .src_valid({ms_rx_valid, kb_rx_valid}),
        .src_data,
        .src_en({!cmd_byte[CB_AUX_DIS], !cmd_byte[CB_KB_DIS]}),
        .src_drop({1'b0, kb_blocked}),
        .src_irq_en({cmd_byte[CB_AUX_IRQ], cmd_byte[CB_KB_IRQ]}),
        .src_ready, .irq, .obf, .aux, .obuf
    );

    assign status = {2'b00, aux, !kb_inhibit_n, ib_is_cmd, cmd_byte[CB_SYS], ibf, obf};

    assign host_rdata  = host_port ? status : obuf;
    assign kb_rx_ready = src_ready[0];
    assign ms_rx_ready = src_ready[1];
    assign kb_tx_data  = tx_data;
    assign ms_tx_data  = tx_data;
    assign irq_kb      = irq[0];
    assign irq_ms      = irq[1];

    assert_kb_dis_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_byte[CB_KB_DIS] |-> !kb_rx_ready);

    assert_ms_dis_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_byte[CB_AUX_DIS] |-> !ms_rx_ready);
endmodule

// File: tb/kbc_host_ctrl_tb_top.sv
module kbc_host_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_port = 1'b1;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       kb_inhibit_n = 1'b1;
    logic       kb_rx_valid = 1'b0, ms_rx_valid = 1'b0;
    logic [7:0] kb_rx_data = '0, ms_rx_data = '0;
    logic       kb_rx_ready, ms_rx_ready;
    logic       kb_tx_valid, ms_tx_valid;
    logic [7:0] kb_tx_data, ms_tx_data;
    logic       kb_tx_ready = 1'b0, ms_tx_ready = 1'b0;
    logic       irq_kb, irq_ms;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    kbc_host_ctrl dut_i (
        .clk, .rst_n, .host_wr, .host_rd, .host_port, .host_wdata, .host_rdata,
        .kb_inhibit_n, .kb_rx_valid, .kb_rx_data, .kb_rx_ready,
        .ms_rx_valid, .ms_rx_data, .ms_rx_ready,
        .kb_tx_valid, .kb_tx_data, .kb_tx_ready,
        .ms_tx_valid, .ms_tx_data, .ms_tx_ready, .irq_kb, .irq_ms
    );

    // kind: 0 = command without reply, 1 = command with reply, 2 = data byte
    localparam int NV = 25;
    localparam logic [23:0] VEC [NV] = '{
        {8'h01, 8'h20, 8'h03}, // R6 reset command byte
        {8'h00, 8'h61, 8'h00}, {8'h02, 8'h5A, 8'h00}, {8'h01, 8'h2F, 8'h5A}, // R7
        {8'h00, 8'h6F, 8'h00}, {8'h02, 8'hC3, 8'h00}, {8'h01, 8'h21, 8'hC3}, // R7
        {8'h01, 8'hAA, 8'h55}, {8'h01, 8'hA9, 8'h00}, {8'h01, 8'hAB, 8'h00}, // R9
        {8'h00, 8'h60, 8'h00}, {8'h02, 8'h07, 8'h00}, {8'h01, 8'h20, 8'h07}, // R6
        {8'h00, 8'hA7, 8'h00}, {8'h01, 8'h20, 8'h27}, {8'h00, 8'hA8, 8'h00}, // R8
        {8'h00, 8'hAD, 8'h00}, {8'h01, 8'h20, 8'h17}, {8'h00, 8'hAE, 8'h00}, // R8
        {8'h01, 8'h20, 8'h07}, {8'h00, 8'h12, 8'h00}, {8'h01, 8'h20, 8'h07}, // R13
        {8'h00, 8'h60, 8'h00}, {8'h02, 8'h03, 8'h00}, {8'h01, 8'h20, 8'h03}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic host_write(input logic port, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_port = port; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_port = 1'b1;
        #1;
    endtask

    task automatic read_data(output logic [7:0] v);
        @(negedge clk);
        host_port = 1'b0; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; host_port = 1'b1;
        #1;
    endtask

    function automatic logic [7:0] status();
        return host_rdata;
    endfunction

    // offers one byte for one clock; returns the ready seen
    task automatic dev_send(input bit mouse, input logic [7:0] d, output logic rdy);
        @(negedge clk);
        if (mouse) begin ms_rx_valid = 1'b1; ms_rx_data = d; end
        else       begin kb_rx_valid = 1'b1; kb_rx_data = d; end
        #1 rdy = mouse ? ms_rx_ready : kb_rx_ready;
        @(negedge clk);
        kb_rx_valid = 1'b0; ms_rx_valid = 1'b0;
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        logic       r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 reset status", status(), 8'h00);
        check("R11 reset irqs", {6'd0, irq_kb, irq_ms}, 8'h00);
        check("R4 reset tx valids", {6'd0, kb_tx_valid, ms_tx_valid}, 8'h00);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [7:0] kind, b, e;
            {kind, b, e} = VEC[i];
            host_write(kind != 8'h02, b);
            step();
            if (kind == 8'h01) begin
                check($sformatf("R9 vec %0d status", i), status() & 8'h23, 8'h01);
                read_data(v);
                check($sformatf("R6 R7 R9 vec %0d reply", i), v, e);
            end else begin
                check($sformatf("R13 vec %0d no reply", i), status() & 8'h03, 8'h00);
            end
        end

        // R1 busy and tag timing, R2 full status after self-test
        host_write(1'b1, 8'hAA);
        check("R1 busy after command write", status() & 8'h0A, 8'h0A);
        step();
        check("R2 status after self-test", status(), 8'h09);
        check("R3 status read no side effect", status(), 8'h09);
        read_data(v);
        check("R3 read returns buffer", v, 8'h55);
        check("R3 read clears full", status() & 8'h01, 8'h00);

        // R2 system flag
        host_write(1'b1, 8'h60); host_write(1'b0, 8'h07); step();
        check("R2 system flag bit", status() & 8'h04, 8'h04);
        host_write(1'b1, 8'h60); host_write(1'b0, 8'h03); step();

        // R4 keyboard transmit
        host_write(1'b0, 8'hED);
        check("R1 data tag and busy", status() & 8'h0A, 8'h02);
        step();
        check("R4 kb tx valid", {7'd0, kb_tx_valid}, 8'h01);
        check("R4 kb tx data", kb_tx_data, 8'hED);
        step(); step();
        check("R4 kb tx held", {6'd0, kb_tx_valid, status()[1]}, 8'h03);
        @(negedge clk); kb_tx_ready = 1'b1;
        @(negedge clk); kb_tx_ready = 1'b0; #1;
        check("R4 kb tx done", {6'd0, kb_tx_valid, status()[1]}, 8'h00);

        // R5 mouse transmit
        host_write(1'b1, 8'hD4); step();
        host_write(1'b0, 8'hF4); step();
        check("R5 ms tx valid only", {6'd0, kb_tx_valid, ms_tx_valid}, 8'h01);
        check("R5 ms tx data", ms_tx_data, 8'hF4);
        @(negedge clk); ms_tx_ready = 1'b1;
        @(negedge clk); ms_tx_ready = 1'b0; #1;
        check("R5 ms tx done", {7'd0, ms_tx_valid}, 8'h00);

        // R10 R11 device input
        dev_send(1'b0, 8'h1C, r);
        check("R10 kb ready when empty", {7'd0, r}, 8'h01);
        check("R11 kb irq set", {6'd0, irq_kb, irq_ms}, 8'h02);
        check("R10 kb source flag", status() & 8'h21, 8'h01);
        dev_send(1'b1, 8'h77, r);
        check("R10 ms blocked when full", {7'd0, r}, 8'h00);
        read_data(v);
        check("R10 kb byte kept", v, 8'h1C);
        check("R3 irq cleared by read", {6'd0, irq_kb, irq_ms}, 8'h00);
        @(negedge clk);
        kb_rx_valid = 1'b1; kb_rx_data = 8'h2A; ms_rx_valid = 1'b1; ms_rx_data = 8'h08;
        #1 check("R10 priority readies", {6'd0, kb_rx_ready, ms_rx_ready}, 8'h02);
        @(negedge clk); kb_rx_valid = 1'b0; #1;
        check("R10 ms waits, buffer full", {7'd0, ms_rx_ready}, 8'h00);
        read_data(v);
        check("R10 kb wins", v, 8'h2A);
        step();
        ms_rx_valid = 1'b0; #1;
        check("R11 ms irq set", {6'd0, irq_kb, irq_ms}, 8'h01);
        check("R10 ms source flag", status() & 8'h21, 8'h21);
        read_data(v);
        check("R10 ms byte", v, 8'h08);

        host_write(1'b1, 8'h60); host_write(1'b0, 8'h00); step();
        dev_send(1'b0, 8'h3B, r);
        check("R11 irq disabled", {6'd0, irq_kb, irq_ms}, 8'h00);
        read_data(v);
        check("R11 byte still loaded", v, 8'h3B);
        host_write(1'b1, 8'h60); host_write(1'b0, 8'h03); step();

        // R12 inhibit
        kb_inhibit_n = 1'b0; #1;
        check("R12 inhibit in status", status() & 8'h10, 8'h10);
        dev_send(1'b0, 8'h45, r);
        check("R12 inhibited byte consumed", {7'd0, r}, 8'h01);
        check("R12 inhibited byte dropped", {6'd0, status()[0], irq_kb}, 8'h00);
        dev_send(1'b1, 8'h09, r);
        check("R12 mouse unaffected", {6'd0, status()[0], irq_ms}, 8'h03);
        read_data(v);
        host_write(1'b1, 8'h60); host_write(1'b0, 8'h0B); step();
        dev_send(1'b0, 8'h46, r);
        check("R12 override passes byte", {7'd0, status()[0]}, 8'h01);
        read_data(v);
        check("R12 override data", v, 8'h46);
        kb_inhibit_n = 1'b1;
        host_write(1'b1, 8'h60); host_write(1'b0, 8'h03); step();

        // R8 disabled keyboard
        host_write(1'b1, 8'hAD); step();
        @(negedge clk); kb_rx_valid = 1'b1; kb_rx_data = 8'h11;
        #1 check("R8 kb ready low when disabled", {7'd0, kb_rx_ready}, 8'h00);
        @(negedge clk); kb_rx_valid = 1'b0;
        host_write(1'b1, 8'hAE); step();

        // R13 command cancels a pending data phase
        host_write(1'b1, 8'h60); step();
        host_write(1'b1, 8'hAA); step();
        read_data(v);
        check("R13 command during wait", v, 8'h55);
        host_write(1'b0, 8'h77); step();
        check("R13 data goes to keyboard", {7'd0, kb_tx_valid}, 8'h01);
        @(negedge clk); kb_tx_ready = 1'b1;
        @(negedge clk); kb_tx_ready = 1'b0;
        host_write(1'b1, 8'h20); step();
        read_data(v);
        check("R13 command byte untouched", v, 8'h03);

        // R14 write while busy is dropped
        @(negedge clk); host_wr = 1'b1; host_port = 1'b1; host_wdata = 8'hAA;
        @(negedge clk); host_wdata = 8'h20;
        @(negedge clk); host_wr = 1'b0; #1;
        step();
        check("R14 busy write dropped", status() & 8'h03, 8'h01);
        read_data(v);
        check("R14 first command kept", v, 8'h55);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule